// File: doc/BRIEF.md
# Greedy angle-recoding CORDIC rotator

This block rotates a two-dimensional vector by a target angle with shift-and-add micro-rotations. It does not walk through every shift in a fixed order. In each cycle it picks, from a set that holds zero and the angles ±atan(2^-s) for s = 1 … N−1, the candidate that lies closest to the residual angle. Every candidate is subtracted from the residual in parallel, and a binary comparator tree reduces the results to the smallest distance. Only that single micro-rotation is applied in the cycle.

The rotated result is a pseudo-vector, and its gain depends on which shifts were used. For this reason the block leaves out any scale correction. Instead it exports the number of micro-rotations and, for each one, the shift and the direction, so that downstream logic can apply the matching gain. A caller pulses `start` with x, y and the angle, then waits for `done`. The results stay valid until the next start.

Top module: `greedy_ar_cordic`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `done`, `rot_count`, `x_out`, `y_out`, `shift_list` and `neg_list` are all zero.
- R2: A `start` pulse while not busy loads the inputs, with x and y sign-extended to W+2 bits. On the next edge it raises `busy`, clears `done`, clears `rot_count` and clears both record lists.
- R3: Angles are signed two's complement with AW−3 fractional bits (radians). The candidate for shift s is round(atan(2^-s)·2^(AW−3)). Each step chooses the candidate c in {0, a_1 … a_{N−1}} that minimises ||z| − c|, with direction d = +1 when z ≥ 0 and −1 otherwise. On a tie, zero wins over any shift, and otherwise the larger shift wins.
- R4: One micro-rotation with shift s takes one clock: x ← x − d·(y >>> s), y ← y + d·(x >>> s), z ← z − d·a_s. The shifts are arithmetic (floor).
- R5: A busy step applies no rotation and ends the run when |z| < a_{N−1} or when zero is the chosen candidate. `done` rises and `busy` falls on the next edge, and `busy` and `done` are never both high.
- R6: At most MAXR = N/2 + 2 micro-rotations are applied. After the MAXR-th one, the next step ends the run with `rot_count` = MAXR.
- R7: Record entry k sits at `shift_list[k*SW +: SW]` (SW = ceil(log2 N)) and at `neg_list[k]`. It holds the shift of the k-th micro-rotation, and the sign bit is 1 for d = −1. Entries at or beyond `rot_count` read zero.
- R8: A `start` that arrives while busy is ignored, and the run in flight completes unchanged.
- R9: While idle and without `start`, the outputs and `done` keep their values, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a rotation with the present inputs |
| x_in | input | W | Signed x component |
| y_in | input | W | Signed y component |
| z_in | input | AW | Signed target angle, AW−3 fractional bits |
| x_out | output | W+2 | Rotated pseudo-vector, x |
| y_out | output | W+2 | Rotated pseudo-vector, y |
| rot_count | output | CW | Number of micro-rotations applied |
| shift_list | output | MAXR·SW | Shift of each applied micro-rotation |
| neg_list | output | MAXR | Direction of each applied micro-rotation, 1 = negative |
| busy | output | 1 | Recoding in progress |
| done | output | 1 | Run finished, outputs valid |

## Verification
The bench uses the defaults W = 16, AW = 16 and N = 12. That gives eleven shift candidates, a cap of eight rotations and an angle range near ±4 rad. Near 3.9 rad the greedy search needs more rotations than the cap allows, so a run stops on the cap. The small residual floor (a_11 = 4) makes the below-floor exit easy to hit with tiny angles. With these candidate values, a_2 + a_3 is even, so an exact midpoint tie between two shifts can be placed on the input.

// File: rtl/greedy_ar_pkg.sv
package greedy_ar_pkg;

  localparam int ATAN_PREC = 40;

  // atan(2^-s) by its odd power series, rounded to frac fractional bits
  function automatic longint atan_pow2_fix(input int s, input int frac);
    longint acc;
    longint term;
    int     e;
    acc = 0;
    for (int k = 0; k < 32; k++) begin
      e = (2 * k + 1) * s;
      if (e <= ATAN_PREC) begin
        term = (longint'(1) <<< (ATAN_PREC - e)) / longint'(2 * k + 1);
        acc  = (k % 2 == 1) ? acc - term : acc + term;
      end
    end
    return (acc + (longint'(1) <<< (ATAN_PREC - frac - 1))) >>> (ATAN_PREC - frac);
  endfunction

endpackage

// File: rtl/greedy_ar_cand_bank.sv
module greedy_ar_cand_bank #(
  parameter int AW = 16,
  parameter int N  = 12,
  parameter int FR = 13,
  parameter int KW = 4,
  parameter int L  = 16
) (
  input  logic [AW:0]             zmag,
  output logic [L-1:0][AW:0]      cost,
  output logic [L-1:0][KW-1:0]    key,
  output logic [L-1:0][AW-1:0]    ang
);
  import greedy_ar_pkg::*;

  for (genvar i = 0; i < L; i++) begin : g_cand
    if (i == 0) begin : g_zero
      // zero candidate: ranks above every shift on a tie
      assign cost[i] = zmag;
      assign key[i]  = KW'(N);
      assign ang[i]  = '0;
    end else if (i < N) begin : g_shift
      localparam logic [AW-1:0] A = AW'(atan_pow2_fix(i, FR));
      logic signed [AW+1:0] diff;
      logic [AW+1:0]        mag;
      assign diff    = $signed({1'b0, zmag}) - $signed({2'b00, A});
      assign mag     = diff[AW+1] ? -diff : diff;
      assign cost[i] = mag[AW:0];
      assign key[i]  = KW'(i);
      assign ang[i]  = A;
    end else begin : g_pad
      assign cost[i] = '1;
      assign key[i]  = '0;
      assign ang[i]  = '0;
    end
  end

endmodule

// File: rtl/greedy_ar_min_tree.sv
module greedy_ar_min_tree #(
  parameter int L   = 16,
  parameter int CWD = 17,
  parameter int KW  = 4,
  localparam int LG = $clog2(L),
  localparam int LW = (LG < 1) ? 1 : LG
) (
  input  logic [L-1:0][CWD-1:0] cost,
  input  logic [L-1:0][KW-1:0]  key,
  output logic [LW-1:0]         best_idx
);

  for (genvar lv = 0; lv <= LG; lv++) begin : g_lv
    localparam int CNT = L >> lv;
    logic [CNT-1:0][CWD-1:0] c;
    logic [CNT-1:0][KW-1:0]  k;
    logic [CNT-1:0][LW-1:0]  ix;
    if (lv == 0) begin : g_leaf
      for (genvar j = 0; j < CNT; j++) begin : g_l
        assign c[j]  = cost[j];
        assign k[j]  = key[j];
        assign ix[j] = LW'(j);
      end
    end else begin : g_node
      for (genvar j = 0; j < CNT; j++) begin : g_n
        logic take_r;
        // right wins when strictly smaller, or equal with higher rank key
        assign take_r = (g_lv[lv-1].c[2*j+1] < g_lv[lv-1].c[2*j]) ||
                        ((g_lv[lv-1].c[2*j+1] == g_lv[lv-1].c[2*j]) &&
                         (g_lv[lv-1].k[2*j+1] > g_lv[lv-1].k[2*j]));
        assign c[j]  = take_r ? g_lv[lv-1].c[2*j+1]  : g_lv[lv-1].c[2*j];
        assign k[j]  = take_r ? g_lv[lv-1].k[2*j+1]  : g_lv[lv-1].k[2*j];
        assign ix[j] = take_r ? g_lv[lv-1].ix[2*j+1] : g_lv[lv-1].ix[2*j];
      end
    end
  end

  assign best_idx = g_lv[LG].ix[0];

endmodule

// File: rtl/greedy_ar_microrot.sv
module greedy_ar_microrot #(
  parameter int XW = 18,
  parameter int AW = 16,
  parameter int SW = 4
) (
  input  logic signed [XW-1:0] x,
  input  logic signed [XW-1:0] y,
  input  logic signed [AW-1:0] z,
  input  logic [SW-1:0]        sh,
  input  logic                 neg,
  input  logic [AW-1:0]        ang,
  output logic signed [XW-1:0] xn,
  output logic signed [XW-1:0] yn,
  output logic signed [AW-1:0] zn
);
  logic signed [XW-1:0] xs, ys;
  logic signed [AW-1:0] a_s;

  assign xs  = x >>> sh;
  assign ys  = y >>> sh;
  assign a_s = $signed(ang);
  assign xn  = neg ? x + ys  : x - ys;
  assign yn  = neg ? y - xs  : y + xs;
  assign zn  = neg ? z + a_s : z - a_s;

endmodule

// File: rtl/greedy_ar_cordic.sv
module greedy_ar_cordic #(
  parameter int W  = 16,
  parameter int AW = 16,
  parameter int N  = 12,
  localparam int XW   = W + 2,
  localparam int MAXR = N / 2 + 2,
  localparam int SW   = $clog2(N),
  localparam int CW   = $clog2(MAXR + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [W-1:0]         x_in,
  input  logic [W-1:0]         y_in,
  input  logic [AW-1:0]        z_in,
  output logic [XW-1:0]        x_out,
  output logic [XW-1:0]        y_out,
  output logic [CW-1:0]        rot_count,
  output logic [MAXR*SW-1:0]   shift_list,
  output logic [MAXR-1:0]      neg_list,
  output logic                 busy,
  output logic                 done
);
  import greedy_ar_pkg::*;

  localparam int FR = AW - 3;
  localparam int KW = $clog2(N + 1);
  localparam int L  = 1 << $clog2(N);
  localparam int LW = $clog2(L);
  localparam logic [AW:0] A_MIN = (AW + 1)'(atan_pow2_fix(N - 1, FR));

  logic signed [XW-1:0] x_r, y_r, xn, yn;
  logic signed [AW-1:0] z_r, zn;
  logic [CW-1:0]        cnt;
  logic                 busy_r, done_r;
  logic [MAXR-1:0][SW-1:0] sh_rec;
  logic [MAXR-1:0]      neg_rec;

  // residual magnitude and candidate search
  logic signed [AW:0]   zx;
  logic [AW:0]          zmag;
  logic [L-1:0][AW:0]   cost;
  logic [L-1:0][KW-1:0] key;
  logic [L-1:0][AW-1:0] ang;
  logic [LW-1:0]        best_idx;

  assign zx   = {z_r[AW-1], z_r};
  assign zmag = zx[AW] ? -zx : zx;

  greedy_ar_cand_bank #(.AW(AW), .N(N), .FR(FR), .KW(KW), .L(L)) u_bank (
    .zmag(zmag), .cost(cost), .key(key), .ang(ang)
  );

  greedy_ar_min_tree #(.L(L), .CWD(AW + 1), .KW(KW)) u_tree (
    .cost(cost), .key(key), .best_idx(best_idx)
  );

  // named step events
  logic below_floor, sel_zero, cap_hit, stop_now, rot_fire, neg_dir;
  logic [SW-1:0] sel_sh;

  assign below_floor = zmag < A_MIN;
  assign sel_zero    = best_idx == '0;
  assign cap_hit     = cnt == CW'(MAXR);
  assign stop_now    = busy_r && (below_floor || sel_zero || cap_hit);
  assign rot_fire    = busy_r && !stop_now;
  assign neg_dir     = z_r[AW-1];
  assign sel_sh      = SW'(best_idx);

  greedy_ar_microrot #(.XW(XW), .AW(AW), .SW(SW)) u_rot (
    .x(x_r), .y(y_r), .z(z_r), .sh(sel_sh), .neg(neg_dir),
    .ang(ang[best_idx]), .xn(xn), .yn(yn), .zn(zn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_r     <= '0;
      y_r     <= '0;
      z_r     <= '0;
      cnt     <= '0;
      busy_r  <= 1'b0;
      done_r  <= 1'b0;
      sh_rec  <= '0;
      neg_rec <= '0;
    end else if (!busy_r && start) begin
      x_r     <= {{2{x_in[W-1]}}, x_in};
      y_r     <= {{2{y_in[W-1]}}, y_in};
      z_r     <= z_in;
      cnt     <= '0;
      busy_r  <= 1'b1;
      done_r  <= 1'b0;
      sh_rec  <= '0;
      neg_rec <= '0;
    end else if (rot_fire) begin
      x_r <= xn;
      y_r <= yn;
      z_r <= zn;
      cnt <= cnt + CW'(1);
      for (int k = 0; k < MAXR; k++) begin
        if (cnt == CW'(k)) begin
          sh_rec[k]  <= sel_sh;
          neg_rec[k] <= neg_dir;
        end
      end
    end else if (stop_now) begin
      busy_r <= 1'b0;
      done_r <= 1'b1;
    end
  end

  assign x_out      = x_r;
  assign y_out      = y_r;
  assign rot_count  = cnt;
  assign shift_list = sh_rec;
  assign neg_list   = neg_rec;
  assign busy       = busy_r;
  assign done       = done_r;

endmodule

// File: rtl/greedy_ar_cordic_chk.sv
module greedy_ar_cordic_chk #(
  parameter int MAXR = 8,
  parameter int CW   = 4,
  parameter int XW   = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          stop_now,
  input logic          rot_fire,
  input logic          below_floor,
  input logic          sel_zero,
  input logic [CW-1:0] rot_count,
  input logic [XW-1:0] x_out,
  input logic [XW-1:0] y_out
);

  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !done && rot_count == '0));

  p_step_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rot_fire |=> (rot_count == $past(rot_count) + CW'(1)));

  p_stop_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_now |=> (done && !busy && rot_count == $past(rot_count)));

  p_floor_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (below_floor || sel_zero)) |-> stop_now);

  p_excl_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_cap_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rot_count == CW'(MAXR)) |-> stop_now);

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rot_count <= CW'(MAXR));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && rot_fire) |=> (busy && rot_count == $past(rot_count) + CW'(1)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(x_out) && $stable(y_out) &&
                           $stable(rot_count) && $stable(done)));

endmodule

bind greedy_ar_cordic greedy_ar_cordic_chk #(.MAXR(MAXR), .CW(CW), .XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .stop_now(stop_now), .rot_fire(rot_fire), .below_floor(below_floor),
  .sel_zero(sel_zero), .rot_count(rot_count), .x_out(x_out), .y_out(y_out)
);

// File: tb/greedy_ar_cordic_tb.sv
module greedy_ar_cordic_tb;
  localparam int W    = 16;
  localparam int AW   = 16;
  localparam int N    = 12;
  localparam int FR   = AW - 3;
  localparam int XW   = W + 2;
  localparam int MAXR = N / 2 + 2;
  localparam int SW   = $clog2(N);
  localparam int CW   = $clog2(MAXR + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start;
  logic [W-1:0] x_in, y_in;
  logic [AW-1:0] z_in;
  logic [XW-1:0] x_out, y_out;
  logic [CW-1:0] rot_count;
  logic [MAXR*SW-1:0] shift_list;
  logic [MAXR-1:0] neg_list;
  logic busy, done;

  greedy_ar_cordic #(.W(W), .AW(AW), .N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
    .z_in(z_in), .x_out(x_out), .y_out(y_out), .rot_count(rot_count),
    .shift_list(shift_list), .neg_list(neg_list), .busy(busy), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit armed = 1'b0;
  int cyc = 0;
  int atab [N];

  // behavioural reference state
  int mx, my, mz, mcount;
  bit mbusy, mdone;
  int msh [MAXR];
  bit mng [MAXR];
  logic [MAXR*SW-1:0] esh;
  logic [MAXR-1:0] eng;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  initial begin
    for (int s = 1; s < N; s++)
      atab[s] = $rtoi($atan(1.0 / (2.0 ** s)) * (2.0 ** FR) + 0.5);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mx = 0; my = 0; mz = 0; mcount = 0; mbusy = 0; mdone = 0;
      for (int k = 0; k < MAXR; k++) begin msh[k] = 0; mng[k] = 0; end
    end else if (!mbusy) begin
      if (start) begin
        mx = int'($signed(x_in)); my = int'($signed(y_in)); mz = int'($signed(z_in));
        mcount = 0; mbusy = 1; mdone = 0;
        for (int k = 0; k < MAXR; k++) begin msh[k] = 0; mng[k] = 0; end
      end
    end else begin
      int az, best, bc, d, tx, ty;
      az = iabs(mz);
      best = 0; bc = az;
      for (int s = N - 1; s >= 1; s--) begin
        if (iabs(az - atab[s]) < bc) begin bc = iabs(az - atab[s]); best = s; end
      end
      if (az < atab[N-1] || best == 0 || mcount == MAXR) begin
        mbusy = 0; mdone = 1;
      end else begin
        d  = (mz < 0) ? -1 : 1;
        tx = mx - d * (my >>> best);
        ty = my + d * (mx >>> best);
        mx = tx; my = ty;
        mz = mz - d * atab[best];
        msh[mcount] = best;
        mng[mcount] = (d < 0);
        mcount++;
      end
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      for (int k = 0; k < MAXR; k++) begin
        esh[k*SW +: SW] = SW'(msh[k]);
        eng[k] = mng[k];
      end
      chk("R2 busy", busy, mbusy);
      chk("R5 done", done, mdone);
      chk("R6 rot_count", rot_count, mcount);
      chk("R4 x_out", $signed(x_out), mx);
      chk("R4 y_out", $signed(y_out), my);
      chk("R7 shift_list", shift_list, esh);
      chk("R3 neg_list", neg_list, eng);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic launch(input int x, input int y, input int z);
    @(posedge clk); #2;
    start = 1'b1; x_in = W'(x); y_in = W'(y); z_in = AW'(z);
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_done();
    int g = 0;
    do begin @(negedge clk); g++; end while (!done && g < 200);
  endtask

  task automatic run(input int x, input int y, input int z);
    launch(x, y, z);
    wait_done();
  endtask

  initial begin
    int tie_s;
    rst_n = 1'b0; start = 1'b0; x_in = '0; y_in = '0; z_in = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 rot_count", rot_count, 0);
    chk("R1 x_out", x_out, 0);
    chk("R1 shift_list", shift_list, 0);
    rst_n = 1'b1;
    armed = 1'b1;

    // zero angle: no rotation at all
    run(1000, 0, 0);
    chk("R5 zero angle count", rot_count, 0);
    chk("R5 zero angle x", $signed(x_out), 1000);

    // exact candidate angle: one rotation, positive direction
    run(20000, -3000, atab[3]);
    chk("R3 single shift", shift_list[SW-1:0], 3);
    chk("R3 single sign", neg_list[0], 0);
    chk("R6 single count", rot_count, 1);
    chk("R4 single x", $signed(x_out), 20375);
    chk("R4 single y", $signed(y_out), -500);

    // negative exact candidate
    run(-5000, 7000, -atab[2]);
    chk("R3 negative shift", shift_list[SW-1:0], 2);
    chk("R7 negative sign", neg_list[0], 1);

    // midpoint tie between two shifts goes to the larger shift
    tie_s = 0;
    for (int s = N - 3; s >= 1; s--)
      if ((atab[s] + atab[s+1]) % 2 == 0) tie_s = s;
    if (tie_s != 0) begin
      run(12000, 0, (atab[tie_s] + atab[tie_s+1]) / 2);
      chk("R3 tie first shift", shift_list[SW-1:0], tie_s + 1);
    end

    // generic angles
    run(30000, 12000, 6434);
    run(-20000, 9000, -9830);
    run(-700, -32768, 410);

    // below the residual floor
    run(5000, 5000, atab[N-1] - 1);
    chk("R5 below floor count", rot_count, 0);

    // large angle runs into the cap
    run(-32768, 32767, 31948);
    chk("R6 cap count", rot_count, MAXR);

    // start while busy is ignored
    launch(12345, -2222, 31948);
    @(posedge clk); #2;
    start = 1'b1; x_in = W'(1); y_in = W'(1); z_in = '0;
    @(posedge clk); #2;
    start = 1'b0;
    wait_done();
    chk("R8 ignored start count", rot_count, MAXR);

    // idle hold while inputs wander
    begin
      logic [XW-1:0] hold_x;
      hold_x = x_out;
      for (int i = 0; i < 5; i++) begin
        @(posedge clk); #2;
        x_in = W'(i * 1111); z_in = AW'(i * 333);
      end
      @(negedge clk);
      chk("R9 idle x_out", x_out, hold_x);
      chk("R9 idle done", done, 1);
    end

    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule